// File: doc/BRIEF.md
# Interrupt Pin Dispatcher with Remote-IRR Coalescing

This block watches a bank of interrupt request pins and turns each pending, unmasked request into a single message-signalled interrupt write, a 32-bit address and a 32-bit data word, offered on a valid/ready port. Each pin has a routing entry supplied as parallel inputs: mask, trigger mode (edge or level), vector, delivery mode, a 16-bit destination and a destination-mode bit. Edge pins latch a rising edge as pending, and delivery consumes it. Level pins are pending while their input is high.

For level pins, a delivered message sets an in-flight flag (remote IRR). While that flag is set, the pin produces no further message, even if it stays asserted. An end-of-interrupt (EOI) carrying a vector clears the flag of every entry whose vector matches. If such an entry is still pending and unmasked, a new service pass starts and the pin is delivered again. A pass also starts on an explicit service request, on an edge-pin rising edge, and on a level-pin rising edge while the flag is clear. Each pass picks the lowest-numbered eligible pin first.

Only one message is outstanding at a time. An EOI that arrives while a message is waiting is held and applied after that message's handshake.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `msg_valid` is low, and no pin is pending or holds remote IRR.
- R2: A rising edge on an unmasked edge-mode pin (`ent_level` bit = 0) produces exactly one message. The handshake clears that pin's pending state.
- R3: When several pins are eligible, messages go out in ascending pin order.
- R4: A masked pin (`ent_mask` bit = 1) is not delivered, and its pending edge is kept. Unmasking it alone starts no delivery. A `svc_req` pulse then delivers it.
- R5: A level-mode pin (`ent_level` bit = 1) held high is delivered once. Its remote IRR is then set, and no further message follows while the flag stays set.
- R6: An EOI whose vector equals a level entry's vector clears that entry's remote IRR, and the pin is delivered again if it is still high and unmasked. An EOI with a different vector has no effect.
- R7: Deasserting a level pin clears its pending state, so a later matching EOI produces no message.
- R8: `msg_addr` = 0xFEE00000 OR (destination << 12) OR (destination mode << 2).
- R9: `msg_data` carries the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger mode in bit 15 (1 = level); all other bits are zero.
- R10: When the delivery mode is 3'b111, the vector in `msg_data` is taken from `ext_vec` when the message is formed, not from the entry.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady. Only one message is in flight at a time.
- R12: An EOI that arrives while a message is outstanding is applied after that message's handshake, and is not lost.
- R13: An entry in edge mode has its remote IRR cleared, so switching a level entry to edge and back re-enables its delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Interrupt request pins |
| ent_mask | input | N | Per-pin mask (1 = masked) |
| ent_level | input | N | Per-pin trigger mode (1 = level, 0 = edge) |
| ent_dmode | input | N | Per-pin destination mode bit |
| ent_vec | input | N*8 | Per-pin vector, pin i at bits 8i+7:8i |
| ent_deliv | input | N*3 | Per-pin delivery mode, pin i at bits 3i+2:3i |
| ent_dest | input | N*16 | Per-pin destination, pin i at bits 16i+15:16i |
| ext_vec | input | 8 | Vector from the legacy controller, used for delivery mode 3'b111 |
| svc_req | input | 1 | Starts a service pass |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector of the end-of-interrupt |
| msg_valid | output | 1 | Message write is valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest case to reach is an EOI that lands while another pin's message is stalled on the output. Reaching it needs a level pin whose remote IRR is already set, a second pin's message held by a low `msg_ready`, and the matching EOI pulsed inside that stall. The stimulus builds this in order: it delivers one level pin and leaves it high, drops `msg_ready`, raises a second pin, and then pulses the EOI. The stall must end with both messages, in order. The remote-IRR reset through an edge-mode toggle is also reached only indirectly. The bench masks the pin, flips its trigger mode and back, and then shows the effect through a service request.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int N = 24,
  parameter logic [31:0] ADDR_BASE = 32'hFEE0_0000,
  parameter int DEST_SH = 12,
  parameter int DMODE_SH = 2,
  parameter logic [2:0] DM_LEGACY = 3'b111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_in,
  input  logic [N-1:0]    ent_mask,
  input  logic [N-1:0]    ent_level,
  input  logic [N-1:0]    ent_dmode,
  input  logic [N*8-1:0]  ent_vec,
  input  logic [N*3-1:0]  ent_deliv,
  input  logic [N*16-1:0] ent_dest,
  input  logic [7:0]      ext_vec,
  input  logic            svc_req,
  input  logic            eoi_valid,
  input  logic [7:0]      eoi_vec,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [31:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  irq_q, pend, rirr, rise, elig, eoi_hit, hs_sel, hs_edge, hs_lvl;
  logic [IW-1:0] sel, cur_idx;
  logic          armed, q_full, load, hs, eoi_go, eoi_arm, arm_set;
  logic [7:0]    q_vec, eoi_use, sel_vec;
  logic [2:0]    sel_deliv;

  assign rise    = irq_in & ~irq_q;
  assign elig    = pend & ~ent_mask & ~(ent_level & rirr);
  assign load    = ~msg_valid & armed & (|elig);
  assign hs      = msg_valid & msg_ready;
  assign eoi_go  = ~msg_valid & (q_full | eoi_valid);
  assign eoi_use = q_full ? q_vec : eoi_vec;
  assign hs_sel  = {N{hs}} & ({{(N-1){1'b0}}, 1'b1} << cur_idx);
  assign hs_edge = hs_sel & {N{~msg_data[15]}};
  assign hs_lvl  = hs_sel & {N{msg_data[15]}};
  assign eoi_arm = |(eoi_hit & pend & ~ent_mask);
  assign arm_set = svc_req | (|(rise & ~ent_level)) | (|(rise & ent_level & ~rirr)) | eoi_arm;

  for (genvar i = 0; i < N; i++) begin : g_eoi
    assign eoi_hit[i] = eoi_go & rirr[i] & (ent_vec[i*8 +: 8] == eoi_use);
  end

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (elig[i]) sel = IW'(i);
  end

  assign sel_deliv = ent_deliv[sel*3 +: 3];
  assign sel_vec   = (sel_deliv == DM_LEGACY) ? ext_vec : ent_vec[sel*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      pend      <= '0;
      rirr      <= '0;
      armed     <= 1'b0;
      q_full    <= 1'b0;
      q_vec     <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      cur_idx   <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= (ent_level & irq_in) | (~ent_level & ((pend & ~hs_edge) | rise));
      rirr  <= (rirr | hs_lvl) & ~eoi_hit & ent_level;

      if (arm_set) armed <= 1'b1;
      else if (~msg_valid & ~(|elig)) armed <= 1'b0;

      if (eoi_valid & (msg_valid | q_full)) begin
        q_full <= 1'b1;
        q_vec  <= eoi_vec;
      end else if (eoi_go & q_full) begin
        q_full <= 1'b0;
      end

      if (load) begin
        msg_valid <= 1'b1;
        cur_idx   <= sel;
        msg_addr  <= ADDR_BASE | (32'(ent_dest[sel*16 +: 16]) << DEST_SH)
                   | (32'(ent_dmode[sel]) << DMODE_SH);
        msg_data  <= {16'h0, ent_level[sel], 4'h0, sel_deliv, sel_vec};
      end else if (hs) begin
        msg_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R11
  AST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr & ADDR_BASE) == ADDR_BASE && msg_addr[1:0] == 2'b00); // R8
  AST_EDGE_NO_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (rirr & ~$past(ent_level)) == '0); // R13
  AST_UNMASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (($past(ent_mask) >> cur_idx) & N'(1)) == '0); // R4
  AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && msg_data[15] |-> (($past(rirr) >> cur_idx) & N'(1)) == '0); // R5
endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int N = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, t_mask = '1, t_level = '0, t_dmode = '0;
  logic [N*8-1:0] t_vec = '0;
  logic [N*3-1:0] t_deliv = '0;
  logic [N*16-1:0] t_dest = '0;
  logic [7:0] ext_vec = '0, eoi_vec = '0;
  logic svc_req = 1'b0, eoi_valid = 1'b0, msg_ready = 1'b1;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;

  int checks = 0, fails = 0, cycles = 0, seen = 0;
  string cur_req = "R1";
  logic [31:0] log_addr[$], log_data[$];

  always #2.5 clk = ~clk;

  irq_dispatch #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ent_mask(t_mask), .ent_level(t_level),
    .ent_dmode(t_dmode), .ent_vec(t_vec), .ent_deliv(t_deliv), .ent_dest(t_dest),
    .ext_vec(ext_vec), .svc_req(svc_req), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic chk(input string req, input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_pend[N], m_rirr[N], m_prev[N];
  bit m_armed, m_valid, m_qf;
  int m_idx;
  logic [7:0] m_qv;
  logic [31:0] m_addr, m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_rirr[i] = 0; m_prev[i] = 0; end
      m_armed = 0; m_valid = 0; m_qf = 0; m_qv = 0; m_idx = 0; m_addr = 0; m_data = 0;
    end else begin
      int pick;
      bit trig, handshake, eoi_now, any_elig;
      logic [7:0] ev;
      logic [7:0] v;
      pick = -1;
      trig = svc_req;
      for (int i = 0; i < N; i++)
        if (pick < 0 && m_pend[i] && !t_mask[i] && !(t_level[i] && m_rirr[i])) pick = i;
      any_elig = (pick >= 0);
      handshake = m_valid && msg_ready;
      eoi_now = !m_valid && (m_qf || eoi_valid);
      ev = m_qf ? m_qv : eoi_vec;
      for (int i = 0; i < N; i++) begin
        bit rising, hit;
        rising = irq_in[i] && !m_prev[i];
        hit = eoi_now && m_rirr[i] && (t_vec[i*8 +: 8] == ev);
        if (rising && (!t_level[i] || !m_rirr[i])) trig = 1;
        if (hit && m_pend[i] && !t_mask[i]) trig = 1;
        if (handshake && m_idx == i && m_data[15]) m_rirr[i] = 1;
        if (hit || !t_level[i]) m_rirr[i] = 0;
        if (t_level[i]) m_pend[i] = irq_in[i];
        else begin
          if (handshake && m_idx == i && !m_data[15]) m_pend[i] = 0;
          if (rising) m_pend[i] = 1;
        end
        m_prev[i] = irq_in[i];
      end
      if (eoi_valid && (m_valid || m_qf)) begin m_qf = 1; m_qv = eoi_vec; end
      else if (eoi_now && m_qf) m_qf = 0;
      if (!m_valid && m_armed && any_elig) begin
        m_idx = pick;
        m_addr = 32'hFEE0_0000 | ({16'h0, t_dest[pick*16 +: 16]} << 12) | (32'(t_dmode[pick]) << 2);
        v = (t_deliv[pick*3 +: 3] == 3'b111) ? ext_vec : t_vec[pick*8 +: 8];
        m_data = {16'h0, t_level[pick], 4'h0, t_deliv[pick*3 +: 3], v};
        m_valid = 1;
      end else if (handshake) m_valid = 0;
      if (trig) m_armed = 1;
      else if (!m_valid && !any_elig) m_armed = 0;
      if (msg_valid && msg_ready) begin
        log_addr.push_back(msg_addr);
        log_data.push_back(msg_data);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cur_req, msg_valid == m_valid, "msg_valid vs model", 64'(msg_valid), 64'(m_valid));
      if (m_valid) begin
        chk(cur_req, msg_addr == m_addr, "msg_addr vs model", 64'(msg_addr), 64'(m_addr));
        chk(cur_req, msg_data == m_data, "msg_data vs model", 64'(msg_data), 64'(m_data));
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ent(input int p, input logic [7:0] vec, input bit lvl, input bit msk,
                         input logic [2:0] dl, input logic [15:0] dst, input bit dm);
    t_vec[p*8 +: 8] = vec; t_level[p] = lvl; t_mask[p] = msk;
    t_deliv[p*3 +: 3] = dl; t_dest[p*16 +: 16] = dst; t_dmode[p] = dm;
  endtask

  task automatic expect_n(input string req, input int n);
    chk(req, log_data.size() - seen == n, "new message count", 64'(log_data.size() - seen), 64'(n));
  endtask

  task automatic expect_msg(input string req, input logic [31:0] a, input logic [31:0] d);
    if (log_data.size() > seen) begin
      chk(req, log_data[seen] == d, "logged data", 64'(log_data[seen]), 64'(d));
      if (a != 0) chk(req, log_addr[seen] == a, "logged addr", 64'(log_addr[seen]), 64'(a));
      seen++;
    end else chk(req, 1'b0, "missing message", 64'(0), 64'(d));
  endtask

  task automatic pulse_eoi(input logic [7:0] v);
    eoi_vec = v; eoi_valid = 1'b1; cyc(1); eoi_valid = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", msg_valid == 1'b0, "valid after reset", 64'(msg_valid), 64'(0));
    svc_req = 1'b1; cyc(1); svc_req = 1'b0; cyc(4);
    expect_n("R1", 0);

    cur_req = "R2";
    set_ent(5, 8'h45, 0, 0, 3'b000, 16'h0012, 1);
    irq_in[5] = 1; cyc(1); irq_in[5] = 0; cyc(6);
    expect_n("R2", 1);
    expect_msg("R8", 32'hFEE1_2004, 32'h0000_0045);
    svc_req = 1'b1; cyc(1); svc_req = 1'b0; cyc(5);
    expect_n("R2", 0);

    cur_req = "R3";
    set_ent(9, 8'h29, 0, 0, 3'b001, 16'h0003, 0);
    set_ent(2, 8'h22, 0, 0, 3'b000, 16'h0001, 0);
    irq_in[9] = 1; irq_in[2] = 1; cyc(1); irq_in[9] = 0; irq_in[2] = 0; cyc(8);
    expect_n("R3", 2);
    expect_msg("R3", 32'hFEE0_1000, 32'h0000_0022);
    expect_msg("R9", 32'hFEE0_3000, 32'h0000_0129);

    cur_req = "R4";
    set_ent(7, 8'h37, 0, 1, 3'b000, 16'h0000, 0);
    irq_in[7] = 1; cyc(1); irq_in[7] = 0; cyc(6);
    expect_n("R4", 0);
    t_mask[7] = 0; cyc(5);
    expect_n("R4", 0);
    svc_req = 1'b1; cyc(1); svc_req = 1'b0; cyc(5);
    expect_n("R4", 1);
    expect_msg("R4", 32'hFEE0_0000, 32'h0000_0037);

    cur_req = "R5";
    set_ent(10, 8'h5A, 1, 0, 3'b000, 16'h0000, 0);
    irq_in[10] = 1; cyc(10);
    expect_n("R5", 1);
    expect_msg("R5", 0, 32'h0000_805A);
    svc_req = 1'b1; cyc(1); svc_req = 1'b0; cyc(6);
    expect_n("R5", 0);

    cur_req = "R6";
    pulse_eoi(8'h11); cyc(6);
    expect_n("R6", 0);
    pulse_eoi(8'h5A); cyc(6);
    expect_n("R6", 1);
    expect_msg("R6", 0, 32'h0000_805A);

    cur_req = "R7";
    irq_in[10] = 0; cyc(3);
    pulse_eoi(8'h5A); cyc(6);
    expect_n("R7", 0);

    cur_req = "R10";
    set_ent(12, 8'h00, 0, 0, 3'b111, 16'h0000, 0);
    ext_vec = 8'h9C;
    irq_in[12] = 1; cyc(1); irq_in[12] = 0; cyc(6);
    expect_n("R10", 1);
    expect_msg("R10", 0, 32'h0000_079C);

    cur_req = "R12";
    set_ent(15, 8'h70, 1, 0, 3'b000, 16'h0000, 0);
    set_ent(14, 8'h66, 1, 0, 3'b000, 16'h0000, 0);
    irq_in[15] = 1; cyc(6);
    expect_n("R12", 1);
    expect_msg("R12", 0, 32'h0000_8070);
    msg_ready = 1'b0;
    irq_in[14] = 1; cyc(4);
    chk("R11", msg_valid == 1'b1, "valid held while stalled", 64'(msg_valid), 64'(1));
    pulse_eoi(8'h70); cyc(5);
    chk("R11", msg_data == 32'h0000_8066, "stalled data", 64'(msg_data), 64'h8066);
    expect_n("R11", 0);
    msg_ready = 1'b1; cyc(8);
    expect_n("R12", 2);
    expect_msg("R12", 0, 32'h0000_8066);
    expect_msg("R12", 0, 32'h0000_8070);

    cur_req = "R13";
    svc_req = 1'b1; cyc(1); svc_req = 1'b0; cyc(5);
    expect_n("R13", 0);
    t_mask[15] = 1; cyc(1);
    t_level[15] = 0; cyc(1);
    t_level[15] = 1; cyc(1);
    t_mask[15] = 0; cyc(1);
    svc_req = 1'b1; cyc(1); svc_req = 1'b0; cyc(6);
    expect_n("R13", 1);
    expect_msg("R13", 0, 32'h0000_8070);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule